// File: doc/BRIEF.md
# Out-of-order issue scheduler with tag-broadcast wakeup

This block is the waiting room between rename and the execution ports. Each renamed instruction lands in a free slot with two physical source tags, a ready flag for each tag, a sequence number and an opaque payload. Every cycle, the result buses carry up to `NUM_BCAST` completed destination tags. Each tag is compared against every waiting source, and a source whose tag matches becomes ready.

From the slots whose sources are all ready, the block picks the oldest ones, up to `ISSUE_W` of them. It presents their payloads on the issue ports, with port 0 carrying the oldest. A tag broadcast in a cycle can release a consumer in that same cycle, because the issue outputs are combinational from the stored state and the live result buses. A slot is released in the cycle it issues.

A flush carrying a sequence boundary discards every slot that is younger than the boundary.

Top module: `wakeup_sched`

## Requirements
- R1: After reset no issue port is valid and `disp_ready_o` is high.
- R2: A dispatch is accepted only when a slot is free and `flush_i` is low. `disp_ready_o` is low when all `NUM_ENTRIES` slots are occupied. A refused dispatch leaves no trace on the issue ports.
- R3: A valid `bc_tag_i[b]` equal to a waiting source tag marks that source ready. Any broadcast port can match either source of any slot.
- R4: A slot is issued only when both of its sources are ready. A slot with any source still waiting never appears on an issue port.
- R5: At most `ISSUE_W` slots issue per cycle, chosen oldest first by dispatch order among eligible slots. Port 0 carries the oldest. `iss_valid_o[p]` implies `iss_valid_o[p-1]`. A younger ready slot issues ahead of an older stalled one.
- R6: A broadcast on the result bus in cycle t lets a consumer whose last missing source matches it issue in cycle t.
- R7: A dispatching instruction whose source tag matches a broadcast in the same cycle is stored with that source ready. If its other source is also ready, it issues in the next cycle.
- R8: An issued slot is freed at the end of its issue cycle, so it issues exactly once and its storage is available to the following dispatch.
- R9: While `flush_i` is high, every slot whose sequence number is younger than `flush_seq_i` is removed and does not issue in that cycle. Younger means that the 8-bit difference seq minus boundary is nonzero with its top bit clear. Older slots and the slot equal to the boundary stay. No dispatch is accepted during a flush.
- R10: An instruction never issues in the cycle in which it is dispatched. It becomes eligible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | A free slot exists and no flush is active |
| disp_tag_i | input | 2x5 | Physical source tags of the dispatching instruction |
| disp_rdy_i | input | 2 | Initial ready flag for each source |
| disp_seq_i | input | 8 | Sequence number, used for flush comparison |
| disp_payload_i | input | 16 | Opaque instruction payload |
| bc_valid_i | input | NUM_BCAST | Result-bus valid flags |
| bc_tag_i | input | NUM_BCAST x 5 | Result-bus destination tags |
| flush_i | input | 1 | Discard slots younger than the boundary |
| flush_seq_i | input | 8 | Flush sequence boundary |
| iss_valid_o | output | ISSUE_W | Issue port valid flags |
| iss_payload_o | output | ISSUE_W x 16 | Issued payloads, port 0 oldest |

## Verification
The hardest state to reach is a full pool in which several waiting slots become ready together on a single broadcast. That is the only situation in which the width cap and oldest-first ordering decide between more than two candidates. A directed sequence reaches it by filling every slot behind one tag that is never broadcast and then releasing that tag.

A flush that lands in the same cycle as a wakeup is equally rare under random traffic. A second directed sequence forces a broadcast and a boundary in one cycle, so that older slots issue while younger ones vanish.

Random traffic then mixes the remaining cases. Dispatches with partly ready sources, completion broadcasts fed back from a fixed three-cycle latency line, stray tags and occasional flushes near the youngest entries are all checked each cycle against a queue model.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int unsigned TAG_W     = 5;
  parameter int unsigned SEQ_W     = 8;
  parameter int unsigned PAYLOAD_W = 16;
  parameter int unsigned SRC_N     = 2;

  typedef logic [TAG_W-1:0]     tag_t;
  typedef logic [SEQ_W-1:0]     seq_t;
  typedef logic [PAYLOAD_W-1:0] pay_t;

  typedef struct packed {
    logic [SRC_N-1:0]   rdy;
    tag_t [SRC_N-1:0]   tag;
    seq_t               seq;
    pay_t               pay;
  } slot_t;

  // a strictly younger than b under wrapping sequence numbers
  function automatic logic seq_younger(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/sched_wakeup.sv
module sched_wakeup
  import sched_pkg::*;
#(
  parameter int unsigned NUM_BCAST = 2
) (
  input  tag_t [SRC_N-1:0]     src_tag_i,
  input  logic [NUM_BCAST-1:0] bc_valid_i,
  input  tag_t [NUM_BCAST-1:0] bc_tag_i,
  output logic [SRC_N-1:0]     hit_o
);
  always_comb begin
    hit_o = '0;
    for (int s = 0; s < SRC_N; s++) begin
      for (int b = 0; b < NUM_BCAST; b++) begin
        if (bc_valid_i[b] && (bc_tag_i[b] == src_tag_i[s])) hit_o[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sched_alloc.sv
module sched_alloc #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] busy_i,
  output logic [N-1:0] pick_o,
  output logic         any_free_o
);
  always_comb begin
    pick_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        pick_o    = '0;
        pick_o[i] = 1'b1;
      end
    end
    any_free_o = ~&busy_i;
  end
endmodule

// File: rtl/sched_age_select.sv
module sched_age_select #(
  parameter int unsigned N       = 8,
  parameter int unsigned ISSUE_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N-1:0]                  alloc_i,
  input  logic [N-1:0]                  busy_i,
  input  logic [N-1:0]                  req_i,
  output logic [N-1:0]                  gnt_o,
  output logic [ISSUE_W-1:0][N-1:0]     sel_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);

  // older_q[i][j]: slot j was dispatched before slot i
  logic [N-1:0][N-1:0] older_q;
  logic [CNT_W-1:0]    rank [N];

  always_comb begin
    gnt_o = '0;
    sel_o = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        rank[i] = rank[i] + CNT_W'(req_i[j] & older_q[i][j]);
      end
      gnt_o[i] = req_i[i] && (rank[i] < CNT_W'(ISSUE_W));
      for (int p = 0; p < ISSUE_W; p++) begin
        sel_o[p][i] = req_i[i] && (rank[i] == CNT_W'(p));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_i[i])      older_q[i][j] <= busy_i[j];
          else if (alloc_i[j]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wakeup_sched.sv
module wakeup_sched
  import sched_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned NUM_BCAST   = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                disp_valid_i,
  output logic                                disp_ready_o,
  input  logic [SRC_N-1:0][TAG_W-1:0]         disp_tag_i,
  input  logic [SRC_N-1:0]                    disp_rdy_i,
  input  logic [SEQ_W-1:0]                    disp_seq_i,
  input  logic [PAYLOAD_W-1:0]                disp_payload_i,
  input  logic [NUM_BCAST-1:0]                bc_valid_i,
  input  logic [NUM_BCAST-1:0][TAG_W-1:0]     bc_tag_i,
  input  logic                                flush_i,
  input  logic [SEQ_W-1:0]                    flush_seq_i,
  output logic [ISSUE_W-1:0]                  iss_valid_o,
  output logic [ISSUE_W-1:0][PAYLOAD_W-1:0]   iss_payload_o
);
  localparam int unsigned N = NUM_ENTRIES;

  slot_t            slot_q [N];
  logic [N-1:0]     valid_q;
  logic [SRC_N-1:0] hit_e   [N];
  logic [SRC_N-1:0] rdy_now [N];
  logic [SRC_N-1:0] disp_hit;
  logic [N-1:0]     kill, req, gnt, pick, alloc_vec;
  logic             any_free, disp_fire;
  logic [ISSUE_W-1:0][N-1:0] sel;

  for (genvar i = 0; i < N; i++) begin : g_wake
    sched_wakeup #(.NUM_BCAST(NUM_BCAST)) u_wake (
      .src_tag_i (slot_q[i].tag),
      .bc_valid_i(bc_valid_i),
      .bc_tag_i  (bc_tag_i),
      .hit_o     (hit_e[i])
    );
  end

  // catch broadcasts racing the dispatch write
  sched_wakeup #(.NUM_BCAST(NUM_BCAST)) u_disp_wake (
    .src_tag_i (disp_tag_i),
    .bc_valid_i(bc_valid_i),
    .bc_tag_i  (bc_tag_i),
    .hit_o     (disp_hit)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rdy_now[i] = slot_q[i].rdy | hit_e[i];
      kill[i]    = flush_i && valid_q[i] && seq_younger(slot_q[i].seq, flush_seq_i);
      req[i]     = valid_q[i] && (&rdy_now[i]) && !kill[i];
    end
  end

  sched_alloc #(.N(N)) u_alloc (
    .busy_i    (valid_q),
    .pick_o    (pick),
    .any_free_o(any_free)
  );

  assign disp_ready_o = any_free && !flush_i;
  assign disp_fire    = disp_valid_i && disp_ready_o;
  assign alloc_vec    = pick & {N{disp_fire}};

  sched_age_select #(.N(N), .ISSUE_W(ISSUE_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .alloc_i(alloc_vec),
    .busy_i (valid_q),
    .req_i  (req),
    .gnt_o  (gnt),
    .sel_o  (sel)
  );

  always_comb begin
    iss_valid_o   = '0;
    iss_payload_o = '0;
    for (int p = 0; p < ISSUE_W; p++) begin
      iss_valid_o[p] = |sel[p];
      for (int i = 0; i < N; i++) begin
        iss_payload_o[p] = iss_payload_o[p] | (slot_q[i].pay & {PAYLOAD_W{sel[p][i]}});
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_vec[i]) begin
          valid_q[i] <= 1'b1;
          slot_q[i]  <= '{rdy: disp_rdy_i | disp_hit, tag: disp_tag_i,
                          seq: disp_seq_i, pay: disp_payload_i};
        end else begin
          valid_q[i]    <= valid_q[i] && !gnt[i] && !kill[i];
          slot_q[i].rdy <= rdy_now[i];
        end
      end
    end
  end
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int unsigned N       = 8,
  parameter int unsigned ISSUE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N-1:0]       valid_q,
  input logic [N-1:0]       gnt,
  input logic               disp_ready_o,
  input logic               flush_i,
  input logic [ISSUE_W-1:0] iss_valid_o
);
  p_full_refuse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_q) |-> !disp_ready_o);

  p_flush_refuse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !disp_ready_o);

  p_grant_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt) <= ISSUE_W);

  p_ports_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(iss_valid_o) == $countones(gnt));

  for (genvar p = 1; p < ISSUE_W; p++) begin : g_ord
    p_port_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[p] |-> iss_valid_o[p-1]);
  end

  for (genvar i = 0; i < N; i++) begin : g_free
    p_free_on_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt[i] |=> !valid_q[i]);
    p_grant_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt[i] |-> valid_q[i]);
  end
endmodule

bind wakeup_sched sched_checker #(.N(NUM_ENTRIES), .ISSUE_W(ISSUE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_q     (valid_q),
  .gnt         (gnt),
  .disp_ready_o(disp_ready_o),
  .flush_i     (flush_i),
  .iss_valid_o (iss_valid_o)
);

// File: tb/wakeup_sched_tb_top.sv
`timescale 1ns/1ps
module wakeup_sched_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             disp_valid, disp_ready, flush;
  logic [1:0][4:0]  disp_tag;
  logic [1:0]       disp_rdy;
  logic [7:0]       disp_seq, flush_seq;
  logic [15:0]      disp_payload;
  logic [1:0]       bc_valid;
  logic [1:0][4:0]  bc_tag;
  logic [1:0]       iss_valid;
  logic [1:0][15:0] iss_payload;

  wakeup_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_ready_o(disp_ready),
    .disp_tag_i(disp_tag), .disp_rdy_i(disp_rdy), .disp_seq_i(disp_seq),
    .disp_payload_i(disp_payload), .bc_valid_i(bc_valid), .bc_tag_i(bc_tag),
    .flush_i(flush), .flush_seq_i(flush_seq),
    .iss_valid_o(iss_valid), .iss_payload_o(iss_payload)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // queue model
  bit         m_v [8];
  logic [4:0] m_t [8][2];
  bit         m_r [8][2];
  int         m_o [8];
  logic [7:0] m_s [8];
  logic [15:0] m_p [8];
  int         ord = 0;
  bit         lat_v [3][2];
  logic [4:0] lat_t [3][2];
  logic [1:0]  s_iv;
  logic [15:0] s_p0, s_p1;
  logic        s_dr;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit yng(logic [7:0] a, logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    return (d != 0) && !d[7];
  endfunction

  task automatic cyc(bit dv, logic [4:0] t0, logic [4:0] t1, bit r0, bit r1, logic [4:0] dst,
                     bit bv0, logic [4:0] bt0, bit bv1, logic [4:0] bt1, bit fl, logic [7:0] fs);
    int g0, g1, cnt, slot;
    bit el [8];
    bit acc, h;
    @(negedge clk);
    disp_valid = dv; disp_tag[0] = t0; disp_tag[1] = t1; disp_rdy = {r1, r0};
    disp_seq = ord[7:0]; disp_payload = {dst, ord[10:0]};
    bc_valid = {bv1, bv0}; bc_tag[0] = bt0; bc_tag[1] = bt1;
    flush = fl; flush_seq = fs;
    #1;
    g0 = -1; g1 = -1; cnt = 0;
    for (int i = 0; i < 8; i++) begin
      bit rd;
      rd = 1;
      if (m_v[i]) cnt++;
      for (int s = 0; s < 2; s++) begin
        h = (bv0 && bt0 == m_t[i][s]) || (bv1 && bt1 == m_t[i][s]);
        if (!(m_r[i][s] || h)) rd = 0;
      end
      el[i] = m_v[i] && rd && !(fl && yng(m_s[i], fs));
    end
    for (int i = 0; i < 8; i++)
      if (el[i] && (g0 < 0 || m_o[i] < m_o[g0])) g0 = i;
    for (int i = 0; i < 8; i++)
      if (el[i] && i != g0 && (g1 < 0 || m_o[i] < m_o[g1])) g1 = i;
    s_iv = iss_valid; s_p0 = iss_payload[0]; s_p1 = iss_payload[1]; s_dr = disp_ready;
    acc = dv && (cnt < 8) && !fl;
    chk("R2 disp_ready", disp_ready, (cnt < 8) && !fl);
    chk("R5 port0 valid", iss_valid[0], g0 >= 0);
    chk("R5 port1 valid", iss_valid[1], g1 >= 0);
    if (g0 >= 0) chk("R5 port0 payload", iss_payload[0], m_p[g0]);
    if (g1 >= 0) chk("R5 port1 payload", iss_payload[1], m_p[g1]);
    @(posedge clk);
    // fixed-latency completion model
    for (int p = 0; p < 2; p++) begin
      lat_v[2][p] = lat_v[1][p]; lat_t[2][p] = lat_t[1][p];
      lat_v[1][p] = lat_v[0][p]; lat_t[1][p] = lat_t[0][p];
    end
    lat_v[0][0] = g0 >= 0; lat_t[0][0] = (g0 >= 0) ? m_p[g0][15:11] : 5'd0;
    lat_v[0][1] = g1 >= 0; lat_t[0][1] = (g1 >= 0) ? m_p[g1][15:11] : 5'd0;
    if (g0 >= 0) m_v[g0] = 0;
    if (g1 >= 0) m_v[g1] = 0;
    for (int i = 0; i < 8; i++) begin
      if (fl && yng(m_s[i], fs)) m_v[i] = 0;
      for (int s = 0; s < 2; s++)
        if ((bv0 && bt0 == m_t[i][s]) || (bv1 && bt1 == m_t[i][s])) m_r[i][s] = 1;
    end
    if (acc) begin
      slot = -1;
      for (int i = 7; i >= 0; i--) if (!m_v[i] && !(i == g0 || i == g1)) slot = i;
      if (slot < 0) for (int i = 0; i < 8; i++) if (!m_v[i]) slot = i;
      m_v[slot] = 1; m_t[slot][0] = t0; m_t[slot][1] = t1; m_o[slot] = ord;
      m_s[slot] = ord[7:0]; m_p[slot] = {dst, ord[10:0]};
      for (int s = 0; s < 2; s++) begin
        h = (bv0 && bt0 == m_t[slot][s]) || (bv1 && bt1 == m_t[slot][s]);
        m_r[slot][s] = (s == 0 ? r0 : r1) || h;
      end
      ord++;
    end
  endtask

  task automatic idle(bit bv0 = 0, logic [4:0] bt0 = 0);
    cyc(0, 0, 0, 1, 1, 0, bv0, bt0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    for (int k = 0; k < 3; k++) for (int p = 0; p < 2; p++) lat_v[k][p] = 0;
    disp_valid = 0; disp_tag = '0; disp_rdy = '0; disp_seq = '0; disp_payload = '0;
    bc_valid = '0; bc_tag = '0; flush = 0; flush_seq = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset iss_valid", iss_valid, 2'b00);
    chk("R1 reset disp_ready", disp_ready, 1'b1);
    rst_n = 1;

    // R10 and R6: dispatch waiting on tag 3, then wake and issue the same cycle
    cyc(1, 3, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R10 no issue at dispatch", s_iv, 2'b00);
    idle(1, 3);
    chk("R6 same-cycle issue valid", s_iv, 2'b01);
    chk("R6 same-cycle payload R3", s_p0, 16'h0800);
    // R7: bypass on dispatch
    cyc(1, 7, 7, 0, 0, 2, 0, 0, 1, 7, 0, 0);
    chk("R7 not issued at dispatch", s_iv, 2'b00);
    idle();
    chk("R7 bypassed payload", {s_iv, s_p0}, {2'b01, 16'h1001});
    // R4: waiting on tag 9
    cyc(1, 9, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      idle();
      chk("R4 waiting slot silent", s_iv, 2'b00);
    end
    // R2: fill behind tag 20
    for (int k = 0; k < 7; k++) cyc(1, 20, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    idle();
    chk("R2 full refuses", s_dr, 1'b0);
    cyc(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 refused no issue", s_iv, 2'b00);
    // R5: seven become ready at once; oldest two first
    idle(1, 20);
    chk("R5 oldest on port0", s_p0, 16'd3);
    chk("R5 next on port1", s_p1, 16'd4);
    idle();
    chk("R8 freed, next pair p0", s_p0, 16'd5);
    chk("R8 freed, next pair p1", s_p1, 16'd6);
    idle(); idle();
    chk("R8 last single", {s_iv, s_p0}, {2'b01, 16'd9});
    // R9: flush concurrent with wakeup
    for (int k = 0; k < 3; k++) cyc(1, 21, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 1, 4, 1, 21, 0, 0, 1, 8'd11);
    chk("R9 dispatch refused in flush", s_dr, 1'b0);
    chk("R9 older issue p0", s_p0, 16'd10);
    chk("R9 boundary issue p1", {s_iv, s_p1}, {2'b11, 16'd11});
    idle(1, 21);
    chk("R9 younger removed", s_iv, 2'b00);
    idle(1, 9);
    chk("R3 late wake of old slot", {s_iv, s_p0}, {2'b01, 16'h1802});

    // random traffic with completion feedback
    for (int n = 0; n < 4000; n++) begin
      bit bv0, bv1, fl;
      logic [4:0] bt0, bt1;
      bv0 = lat_v[2][0]; bt0 = lat_t[2][0];
      bv1 = lat_v[2][1]; bt1 = lat_t[2][1];
      if (!bv0 && ($urandom % 4 == 0)) begin bv0 = 1; bt0 = 5'($urandom % 16); end
      if (!bv1 && ($urandom % 4 == 0)) begin bv1 = 1; bt1 = 5'($urandom % 16); end
      fl = ($urandom % 64) == 0;
      cyc($urandom % 4 != 0, 5'($urandom % 16), 5'($urandom % 16),
          $urandom % 3 != 0, $urandom % 3 != 0, 5'($urandom % 16),
          bv0, bt0, bv1, bt1, fl, 8'(ord - 1 - ($urandom % 4)));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule